// File: doc/BRIEF.md
# ModR/M Effective Address Generator

This block turns a 16-bit x86-style addressing byte (mode in bits 7:6, register field in bits 5:3, r/m in bits 2:0) and up to two following displacement bytes into an operand location. It first decides whether the operand is a register or a memory location. For a register operand it reports which register is meant, using the byte/word width flag. For a memory operand it adds the selected base and index register values to the displacement, chooses the default segment, applies an optional segment override, and reports how many displacement bytes the instruction consumes. The caller uses that count to advance past the displacement.

The address logic is combinational and feeds one registered output stage with a valid flag. A result appears one clock after the request is presented. The register values and displacement bytes come from the surrounding decoder, which also owns the register file and instruction fetch.

Top module: `modrm_ea_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero after that edge, including `out_valid`.
- R2: When `in_valid` is high at a rising edge, the result for the inputs sampled at that edge is on the outputs after that edge, with `out_valid` high and `reg_field` equal to addressing-byte bits 5:3. When `in_valid` is low, `out_valid` goes low and all other outputs hold their values.
- R3: Mode 11 gives a register operand: `is_reg`=1, `reg_sel`={`wide`, r/m}. Codes 0..7 are AL,CL,DL,BL,AH,CH,DH,BH and codes 8..15 are AX,CX,DX,BX,SP,BP,SI,DI. In this case `ea`=0, `disp_len`=0 and `seg`=11, and the override inputs are ignored. For memory operands `is_reg`=0 and `reg_sel`=0.
- R4: `disp_len` is 0 for mode 00, except that it is 2 when r/m=110; it is 1 for mode 01 and 2 for mode 10. It never reads 3.
- R5: The memory base for r/m 000..111 is, in turn: BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX.
- R6: In mode 01, `disp_lo` is sign-extended and added. In mode 10, {`disp_hi`,`disp_lo`} is added. The sum wraps modulo 2^16.
- R7: Mode 00 with r/m=110 is a direct address: `ea`={`disp_hi`,`disp_lo`}, no BP term is added, and the default segment is DS.
- R8: The segment codes are ES=00, CS=01, SS=10, DS=11. Memory forms that use BP (r/m 010, r/m 011, and r/m 110 in modes 01 and 10) default to SS. All other memory forms default to DS.
- R9: For a memory operand, a high `ovr_valid` makes `seg` equal `ovr_seg`. A low `ovr_valid` leaves `ovr_seg` without effect.
- R10: Displacement bytes that are not consumed have no effect on `ea`: both bytes in mode 00 with r/m other than 110, and `disp_hi` in mode 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| modrm | input | 8 | Addressing byte |
| wide | input | 1 | 1 = word register set, 0 = byte register set |
| bx_val | input | AW | Current BX value |
| bp_val | input | AW | Current BP value |
| si_val | input | AW | Current SI value |
| di_val | input | AW | Current DI value |
| disp_lo | input | 8 | First displacement byte |
| disp_hi | input | 8 | Second displacement byte |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| out_valid | output | 1 | Registered result valid |
| is_reg | output | 1 | Operand is a register |
| reg_sel | output | 4 | Register code {wide, r/m} |
| reg_field | output | 3 | Addressing-byte bits 5:3, kept aligned with the result |
| ea | output | AW | Effective offset |
| seg | output | 2 | Selected segment code |
| disp_len | output | 2 | Displacement bytes consumed |

## Verification
The bench builds the block with its default AW of 16, which matches the 16-bit offset arithmetic. At this width every one of the 256 addressing bytes can be swept with both width flags, and each is run with the override both off and on. Register and displacement values are random, so sign extension, wraparound and the ignored displacement bytes get many distinct operands. Directed vectors cover the carry-out wrap, a negative byte displacement, reset in the middle of a run, and the hold behaviour while idle.

// File: rtl/modrm_ea_pkg.sv
package modrm_ea_pkg;
  typedef enum logic [1:0] {
    SEG_ES = 2'b00,
    SEG_CS = 2'b01,
    SEG_SS = 2'b10,
    SEG_DS = 2'b11
  } seg_e;

  typedef enum logic [1:0] {
    DSP_NONE = 2'd0,
    DSP_BYTE = 2'd1,
    DSP_WORD = 2'd2
  } dsp_e;

  typedef struct packed {
    logic bx;
    logic bp;
    logic si;
    logic di;
  } base_t;

  localparam logic [1:0] MODE_REG = 2'b11;
  localparam logic [2:0] RM_DIRECT = 3'b110;
endpackage

// File: rtl/modrm_ea_decode.sv
module modrm_ea_decode
  import modrm_ea_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [2:0] rm,
  output logic       is_reg,
  output base_t      base,
  output dsp_e       dsp,
  output seg_e       dflt
);
  logic direct;

  always_comb begin
    is_reg = (mode == MODE_REG);
    direct = (mode == 2'b00) && (rm == RM_DIRECT);
    base   = '0;
    unique case (rm)
      3'd0: begin base.bx = 1'b1; base.si = 1'b1; end
      3'd1: begin base.bx = 1'b1; base.di = 1'b1; end
      3'd2: begin base.bp = 1'b1; base.si = 1'b1; end
      3'd3: begin base.bp = 1'b1; base.di = 1'b1; end
      3'd4: base.si = 1'b1;
      3'd5: base.di = 1'b1;
      3'd6: base.bp = !direct;
      default: base.bx = 1'b1;
    endcase
    if (is_reg) base = '0;

    unique case (mode)
      2'b00:   dsp = direct ? DSP_WORD : DSP_NONE;
      2'b01:   dsp = DSP_BYTE;
      2'b10:   dsp = DSP_WORD;
      default: dsp = DSP_NONE;
    endcase

    dflt = (!is_reg && base.bp) ? SEG_SS : SEG_DS;
  end
endmodule

// File: rtl/modrm_ea_sum.sv
module modrm_ea_sum
  import modrm_ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  base_t          base,
  input  dsp_e           dsp,
  input  logic [AW-1:0]  bx_val,
  input  logic [AW-1:0]  bp_val,
  input  logic [AW-1:0]  si_val,
  input  logic [AW-1:0]  di_val,
  input  logic [7:0]     disp_lo,
  input  logic [7:0]     disp_hi,
  output logic [AW-1:0]  ea
);
  logic [AW-1:0] b_term, i_term, d_term;

  always_comb begin
    b_term = base.bx ? bx_val : (base.bp ? bp_val : '0);
    i_term = base.si ? si_val : (base.di ? di_val : '0);
    unique case (dsp)
      DSP_BYTE: d_term = AW'($signed(disp_lo));
      DSP_WORD: d_term = AW'({disp_hi, disp_lo});
      default:  d_term = '0;
    endcase
    ea = b_term + i_term + d_term;
  end
endmodule

// File: rtl/modrm_ea_seg.sv
module modrm_ea_seg
  import modrm_ea_pkg::*;
(
  input  logic       is_reg,
  input  seg_e       dflt,
  input  logic       ovr_valid,
  input  logic [1:0] ovr_seg,
  output seg_e       seg
);
  always_comb begin
    if (is_reg)         seg = SEG_DS;
    else if (ovr_valid) seg = seg_e'(ovr_seg);
    else                seg = dflt;
  end
endmodule

// File: rtl/modrm_ea_unit.sv
module modrm_ea_unit
  import modrm_ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    modrm,
  input  logic          wide,
  input  logic [AW-1:0] bx_val,
  input  logic [AW-1:0] bp_val,
  input  logic [AW-1:0] si_val,
  input  logic [AW-1:0] di_val,
  input  logic [7:0]    disp_lo,
  input  logic [7:0]    disp_hi,
  input  logic          ovr_valid,
  input  logic [1:0]    ovr_seg,
  output logic          out_valid,
  output logic          is_reg,
  output logic [3:0]    reg_sel,
  output logic [2:0]    reg_field,
  output logic [AW-1:0] ea,
  output logic [1:0]    seg,
  output logic [1:0]    disp_len
);
  logic          c_is_reg;
  base_t         c_base;
  dsp_e          c_dsp;
  seg_e          c_dflt;
  seg_e          c_seg;
  logic [AW-1:0] c_ea;
  logic [3:0]    c_sel;

  modrm_ea_decode u_dec (
    .mode   (modrm[7:6]),
    .rm     (modrm[2:0]),
    .is_reg (c_is_reg),
    .base   (c_base),
    .dsp    (c_dsp),
    .dflt   (c_dflt)
  );

  modrm_ea_sum #(.AW(AW)) u_sum (
    .base    (c_base),
    .dsp     (c_dsp),
    .bx_val  (bx_val),
    .bp_val  (bp_val),
    .si_val  (si_val),
    .di_val  (di_val),
    .disp_lo (disp_lo),
    .disp_hi (disp_hi),
    .ea      (c_ea)
  );

  modrm_ea_seg u_seg (
    .is_reg    (c_is_reg),
    .dflt      (c_dflt),
    .ovr_valid (ovr_valid),
    .ovr_seg   (ovr_seg),
    .seg       (c_seg)
  );

  assign c_sel = c_is_reg ? {wide, modrm[2:0]} : 4'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      is_reg    <= 1'b0;
      reg_sel   <= '0;
      reg_field <= '0;
      ea        <= '0;
      seg       <= '0;
      disp_len  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        is_reg    <= c_is_reg;
        reg_sel   <= c_sel;
        reg_field <= modrm[5:3];
        ea        <= c_ea;
        seg       <= c_seg;
        disp_len  <= c_dsp;
      end
    end
  end
endmodule

// File: rtl/modrm_ea_chk.sv
module modrm_ea_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [7:0]    modrm,
  input logic [7:0]    disp_lo,
  input logic [7:0]    disp_hi,
  input logic          ovr_valid,
  input logic [1:0]    ovr_seg,
  input logic          out_valid,
  input logic          is_reg,
  input logic [AW-1:0] ea,
  input logic [1:0]    seg,
  input logic [1:0]    disp_len
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && ea == '0 && seg == 2'b00));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid) |=> out_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst && !in_valid) |=> (!out_valid && $stable(ea) && $stable(seg)));

  assert_reg_operand_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && is_reg) |-> (ea == '0 && disp_len == 2'd0 && seg == 2'b11));

  assert_len_range_R4: assert property (@(posedge clk) disable iff (rst)
    disp_len != 2'd3);

  assert_len_byte_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid && modrm[7:6] == 2'b01) |=> (disp_len == 2'd1));

  assert_direct_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid && modrm[7:6] == 2'b00 && modrm[2:0] == 3'b110)
      |=> (ea == AW'($past({disp_hi, disp_lo})) && disp_len == 2'd2));

  assert_default_ss_R8: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid && !ovr_valid && modrm[7:6] != 2'b11 && modrm[2:1] == 2'b01)
      |=> (seg == 2'b10));

  assert_override_R9: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid && ovr_valid && modrm[7:6] != 2'b11)
      |=> (seg == $past(ovr_seg)));
endmodule

bind modrm_ea_unit modrm_ea_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .modrm     (modrm),
  .disp_lo   (disp_lo),
  .disp_hi   (disp_hi),
  .ovr_valid (ovr_valid),
  .ovr_seg   (ovr_seg),
  .out_valid (out_valid),
  .is_reg    (is_reg),
  .ea        (ea),
  .seg       (seg),
  .disp_len  (disp_len)
);

// File: tb/tb_modrm_ea_unit.sv
module tb_modrm_ea_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    modrm = '0;
  logic          wide = 1'b0;
  logic [AW-1:0] bx_val = '0, bp_val = '0, si_val = '0, di_val = '0;
  logic [7:0]    disp_lo = '0, disp_hi = '0;
  logic          ovr_valid = 1'b0;
  logic [1:0]    ovr_seg = '0;
  logic          out_valid, is_reg;
  logic [3:0]    reg_sel;
  logic [2:0]    reg_field;
  logic [AW-1:0] ea;
  logic [1:0]    seg, disp_len;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modrm_ea_unit #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .modrm(modrm), .wide(wide),
    .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val), .di_val(di_val),
    .disp_lo(disp_lo), .disp_hi(disp_hi), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
    .out_valid(out_valid), .is_reg(is_reg), .reg_sel(reg_sel), .reg_field(reg_field),
    .ea(ea), .seg(seg), .disp_len(disp_len)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s modrm=%02h: actual=%0h expected=%0h", tag, what, modrm, act, exp);
    end
  endtask

  task automatic run_one(input logic [7:0] m, input logic w, input logic ov,
                         input logic [1:0] os, input logic [15:0] rbx, input logic [15:0] rbp,
                         input logic [15:0] rsi, input logic [15:0] rdi,
                         input logic [7:0] dl, input logic [7:0] dh);
    int md, rm, base, d;
    logic [15:0] e_ea;
    logic [1:0] e_seg, e_len;
    @(negedge clk);
    modrm = m; wide = w; ovr_valid = ov; ovr_seg = os;
    bx_val = rbx; bp_val = rbp; si_val = rsi; di_val = rdi;
    disp_lo = dl; disp_hi = dh; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    md = int'(m[7:6]); rm = int'(m[2:0]);
    chk("R2", {31'd0, out_valid}, 32'd1, "out_valid");
    chk("R2", {29'd0, reg_field}, {29'd0, m[5:3]}, "reg_field");
    if (md == 3) begin
      chk("R3", {31'd0, is_reg}, 32'd1, "is_reg");
      chk("R3", {28'd0, reg_sel}, {28'd0, w, m[2:0]}, "reg_sel");
      chk("R3", {16'd0, ea}, 32'd0, "ea");
      chk("R3", {30'd0, disp_len}, 32'd0, "disp_len");
      chk("R3", {30'd0, seg}, 32'd3, "seg");
    end else begin
      case (rm)
        0: base = rbx + rsi;
        1: base = rbx + rdi;
        2: base = rbp + rsi;
        3: base = rbp + rdi;
        4: base = rsi;
        5: base = rdi;
        6: base = (md == 0) ? 0 : rbp;
        default: base = rbx;
      endcase
      if (md == 0) d = (rm == 6) ? int'({dh, dl}) : 0;
      else if (md == 1) d = (dl >= 8'd128) ? int'(dl) - 256 : int'(dl);
      else d = int'({dh, dl});
      e_ea = 16'(base + d);
      e_len = (md == 0) ? ((rm == 6) ? 2'd2 : 2'd0) : 2'(md);
      if (ov) e_seg = os;
      else if (rm == 2 || rm == 3 || (rm == 6 && md != 0)) e_seg = 2'b10;
      else e_seg = 2'b11;
      chk("R3", {31'd0, is_reg}, 32'd0, "is_reg");
      chk("R3", {28'd0, reg_sel}, 32'd0, "reg_sel");
      if (md == 0 && rm == 6) chk("R7", {16'd0, ea}, {16'd0, e_ea}, "ea");
      else if (md == 0) chk("R5/R10", {16'd0, ea}, {16'd0, e_ea}, "ea");
      else chk("R6/R10", {16'd0, ea}, {16'd0, e_ea}, "ea");
      chk("R4", {30'd0, disp_len}, {30'd0, e_len}, "disp_len");
      chk(ov ? "R9" : "R8", {30'd0, seg}, {30'd0, e_seg}, "seg");
    end
  endtask

  task automatic check_cleared(input string tag);
    chk(tag, {31'd0, out_valid}, 32'd0, "out_valid");
    chk(tag, {31'd0, is_reg}, 32'd0, "is_reg");
    chk(tag, {16'd0, ea}, 32'd0, "ea");
    chk(tag, {30'd0, seg}, 32'd0, "seg");
    chk(tag, {30'd0, disp_len}, 32'd0, "disp_len");
    chk(tag, {28'd0, reg_sel}, 32'd0, "reg_sel");
  endtask

  initial begin
    logic [15:0] h_ea;
    logic [1:0]  h_seg;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_cleared("R1");

    for (int m = 0; m < 256; m++) begin
      for (int w = 0; w < 2; w++) begin
        for (int p = 0; p < 2; p++) begin
          run_one(8'(m), w[0], p[0], 2'($urandom), 16'($urandom), 16'($urandom),
                  16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom));
        end
      end
    end

    // R6: carry-out wraps, and a negative byte displacement
    run_one(8'b10_000_000, 1'b0, 1'b0, 2'b00, 16'hFFFF, 16'h0, 16'hFFFF, 16'h0, 8'hFF, 8'hFF);
    run_one(8'b01_000_111, 1'b1, 1'b0, 2'b00, 16'h0010, 16'h0, 16'h0, 16'h0, 8'h80, 8'h5A);
    // R10: mode 00 with both bytes set, disp_hi in mode 01
    run_one(8'b00_000_100, 1'b0, 1'b0, 2'b00, 16'h1, 16'h2, 16'h1234, 16'h3, 8'hAB, 8'hCD);
    run_one(8'b01_000_101, 1'b0, 1'b0, 2'b00, 16'h1, 16'h2, 16'h3, 16'h1000, 8'h7F, 8'hEE);

    // R2: idle cycle holds outputs despite changed inputs
    h_ea = ea; h_seg = seg;
    @(negedge clk);
    modrm = 8'b10_000_010; bp_val = 16'h4444; disp_lo = 8'h11; ovr_valid = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2", {31'd0, out_valid}, 32'd0, "idle out_valid");
    chk("R2", {16'd0, ea}, {16'd0, h_ea}, "idle ea");
    chk("R2", {30'd0, seg}, {30'd0, h_seg}, "idle seg");

    // R1: reset in the middle of a run
    run_one(8'b10_011_001, 1'b1, 1'b1, 2'b01, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h55, 8'h66);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_cleared("R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule